// File: doc/BRIEF.md
# DMA Request Descriptor Sequencer

This block accepts one already-fetched request descriptor and walks it through a fixed sequence of execution phases. It decodes the command byte, the doorbell attribute byte and a set of semaphore command words, then drives three downstream agents in a strict order over valid/ready handshakes. First goes a semaphore unit (a gating check before the transfer, then the operations after it). Next comes a DMA mover, which also returns a separate done pulse when the transfer finishes. Last is a write master that rings the doorbell. When the descriptor asks for it, the block then offers a completion record carrying the request ID, a status code and an interrupt-force flag.

The descriptor is checked for consistency before any phase starts. An illegal transfer type, a doubly gated request, a reserved doorbell width or a doorbell address that does not fit its width ends the request at once with a non-zero status, and no downstream agent sees a request. The block handles one descriptor at a time and only accepts a new one while idle. Descriptor fetch, semaphore storage and the data mover itself sit outside the block.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `desc_ready` is 1 and none of `sem_valid`, `dma_valid`, `wr_valid`, `cpl_valid` is asserted. A descriptor is taken on a clock edge where `desc_valid` and `desc_ready` are both 1.
- R2: Command bits 1:0 select the transfer: 0 issues no DMA request, 1 issues one with `dma_dir`=1 (host to device), 2 issues one with `dma_dir`=2 (device to host). `dma_bulk` carries command bit 3 (1 bulk, 0 linked list).
- R3: Phases run strictly in this order, with at most one request valid at any time. A semaphore word with bit 31 and bit 22 set (the gating word) is issued first. Then comes the DMA request, and the block waits for `dma_done`. Then every enabled word with bit 22 clear is issued in ascending slot order. The doorbell write comes last.
- R4: Doorbell attribute bit 7 enables the doorbell write. Bits 1:0 give its width, which appears on `wr_size`: 0 means 32 bits, 1 means 16 bits, 2 means 8 bits. `wr_data` carries only the low bits of the doorbell data for that width, and the higher bits are zero.
- R5: An enabled doorbell must be naturally aligned. A 32-bit write needs address bits 1:0 equal to 0. A 16-bit write needs address bit 0 equal to 0. An 8-bit write may use any address.
- R6: Status codes are 1 for transfer type 3, 4 for more than one gating word, 2 for width code 3 with the doorbell enabled, and 3 for a misaligned enabled doorbell. When several apply, the priority order is 1, then 4, then 2, then 3. On any error no semaphore, DMA or doorbell request is issued.
- R7: Command bit 4 asks for a completion record. If it is set, one record is offered after the last phase, or straight away on error. The record carries the request ID, the status (0 = success) and `cpl_irq` = command bit 7. If bit 4 is clear, no record is offered.
- R8: Semaphore words with bit 31 clear are never issued. With no gating word, the DMA phase starts without any semaphore request.
- R9: Every valid output, together with its payload, stays unchanged until its ready input is seen.
- R10: Reset in the middle of a request returns the block to idle with no request outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor can be taken |
| desc_req_id | input | 16 | Request ID |
| desc_cmd | input | 8 | Command byte |
| desc_src | input | AW | Bulk source or list address |
| desc_dst | input | AW | Bulk destination address |
| desc_len | input | LW | Bulk length |
| desc_db_addr | input | AW | Doorbell address |
| desc_db_attr | input | 8 | Doorbell attribute byte |
| desc_db_data | input | 32 | Doorbell data |
| desc_sem | input | NSEM*32 | Semaphore words, slot 0 in the low bits |
| sem_valid | output | 1 | Semaphore command offered |
| sem_ready | input | 1 | Semaphore command completed |
| sem_word | output | 32 | Semaphore command word |
| dma_valid | output | 1 | Transfer request offered |
| dma_ready | input | 1 | Transfer request taken |
| dma_dir | output | 2 | 1 host to device, 2 device to host |
| dma_bulk | output | 1 | 1 bulk, 0 linked list |
| dma_src | output | AW | Source or list address |
| dma_dst | output | AW | Destination address |
| dma_len | output | LW | Transfer length |
| dma_done | input | 1 | Transfer finished pulse |
| wr_valid | output | 1 | Doorbell write offered |
| wr_ready | input | 1 | Doorbell write taken |
| wr_addr | output | AW | Doorbell address |
| wr_data | output | 32 | Doorbell data, masked to width |
| wr_size | output | 2 | Width code |
| cpl_valid | output | 1 | Completion record offered |
| cpl_ready | input | 1 | Completion record taken |
| cpl_req_id | output | 16 | Request ID of the record |
| cpl_status | output | 16 | 0 success, else error code |
| cpl_irq | output | 1 | Force-interrupt flag |

## Verification
The main function is driven with descriptors that combine a gating word, mixed enabled and disabled semaphore slots, each transfer type and each doorbell width. The order in which requests reach the agents shows whether gating and post-transfer words are told apart and sorted correctly, and whether disabled slots are skipped. Error descriptors carry several faults at once, which separates the priority between codes. Other descriptors carry a reserved width or an odd address with the doorbell disabled, which shows that those checks apply only when the write is enabled. A held completion, a held transfer and a reset in mid-request show that payloads stay stable under back-pressure and that recovery works.

// File: rtl/dsq_pkg.sv
// Shared types and constants for the descriptor sequencer.
// Assumes the command and attribute bytes follow the bit layout in the brief.
package dsq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_DMA,
        S_DMAW,
        S_POST,
        S_DB,
        S_CPL
    } dsq_state_e;

    localparam logic [15:0] ST_OK        = 16'd0;
    localparam logic [15:0] ST_BAD_XFER  = 16'd1;
    localparam logic [15:0] ST_BAD_WIDTH = 16'd2;
    localparam logic [15:0] ST_MISALIGN  = 16'd3;
    localparam logic [15:0] ST_MULTI_PRE = 16'd4;

    localparam logic [1:0] XF_NONE    = 2'd0;
    localparam logic [1:0] XF_ILLEGAL = 2'd3;

    localparam logic [1:0] DBW_32  = 2'd0;
    localparam logic [1:0] DBW_16  = 2'd1;
    localparam logic [1:0] DBW_8   = 2'd2;
    localparam logic [1:0] DBW_RSV = 2'd3;

    localparam int CMD_BULK_BIT = 3;
    localparam int CMD_CPL_BIT  = 4;
    localparam int CMD_IRQ_BIT  = 7;
    localparam int ATTR_EN_BIT  = 7;
    localparam int SEM_EN_BIT   = 31;
    localparam int SEM_PRE_BIT  = 22;

endpackage

// File: rtl/dsq_lsb_pick.sv
// Finds the lowest set bit of a mask and returns its index.
// Assumes N >= 1; idx is 0 when no bit is set.
module dsq_lsb_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dsq_db_shape.sv
// Masks doorbell data to the encoded width and checks natural alignment.
// Assumes only the two low address bits matter for alignment.
module dsq_db_shape (
    input  logic [1:0]  size,
    input  logic [1:0]  addr_lo,
    input  logic [31:0] data_in,
    output logic [31:0] data_out,
    output logic        misaligned
);
    import dsq_pkg::*;

    // Keep only the bytes that belong to the selected width.
    always_comb begin
        case (size)
            DBW_16:  data_out = {16'h0, data_in[15:0]};
            DBW_8:   data_out = {24'h0, data_in[7:0]};
            default: data_out = data_in;
        endcase
    end

    // A width is misaligned when its address has low bits set.
    always_comb begin
        case (size)
            DBW_32:  misaligned = (addr_lo != 2'b00);
            DBW_16:  misaligned = addr_lo[0];
            default: misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsq_decode.sv
// Decodes a held descriptor into phase controls and an error status.
// Assumes its inputs stay stable while a request is in flight.
module dsq_decode #(
    parameter int NSEM = 4,
    localparam int SIW = (NSEM > 1) ? $clog2(NSEM) : 1
) (
    input  logic [7:0]        cmd,
    input  logic [7:0]        attr,
    input  logic              db_misaligned,
    input  logic [NSEM*32-1:0] sem,
    output logic [1:0]        xfer,
    output logic              bulk,
    output logic              cpl_en,
    output logic              irq,
    output logic              db_en,
    output logic [1:0]        db_size,
    output logic              pre_found,
    output logic [SIW-1:0]    pre_idx,
    output logic [NSEM-1:0]   post_mask,
    output logic [15:0]       status
);
    import dsq_pkg::*;

    logic [NSEM-1:0] pre_mask;
    logic            multi_pre;

    assign xfer    = cmd[1:0];
    assign bulk    = cmd[CMD_BULK_BIT];
    assign cpl_en  = cmd[CMD_CPL_BIT];
    assign irq     = cmd[CMD_IRQ_BIT];
    assign db_en   = attr[ATTR_EN_BIT];
    assign db_size = attr[1:0];

    // Split each enabled semaphore word into the gating or the trailing group.
    for (genvar g = 0; g < NSEM; g++) begin : g_slot
        assign pre_mask[g]  = sem[g*32 + SEM_EN_BIT] &  sem[g*32 + SEM_PRE_BIT];
        assign post_mask[g] = sem[g*32 + SEM_EN_BIT] & ~sem[g*32 + SEM_PRE_BIT];
    end

    dsq_lsb_pick #(.N(NSEM)) u_pre_pick (
        .mask  (pre_mask),
        .found (pre_found),
        .idx   (pre_idx)
    );

    // Flag more than one gating word.
    always_comb begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < NSEM; i++) cnt += int'(pre_mask[i]);
        multi_pre = (cnt > 1);
    end

    // Pick the status by fixed priority.
    always_comb begin
        if (xfer == XF_ILLEGAL)                status = ST_BAD_XFER;
        else if (multi_pre)                    status = ST_MULTI_PRE;
        else if (db_en && db_size == DBW_RSV)  status = ST_BAD_WIDTH;
        else if (db_en && db_misaligned)       status = ST_MISALIGN;
        else                                   status = ST_OK;
    end
endmodule

// File: rtl/dma_desc_seq.sv
// Sequences one request descriptor through its phases: gating semaphore,
// DMA, trailing semaphores, doorbell, completion record.
// Assumes the downstream agents follow valid/ready handshakes and that the
// DMA mover pulses dma_done only after taking a request.
module dma_desc_seq #(
    parameter int AW   = 64,
    parameter int LW   = 32,
    parameter int NSEM = 4,
    localparam int SIW = (NSEM > 1) ? $clog2(NSEM) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [15:0]        desc_req_id,
    input  logic [7:0]         desc_cmd,
    input  logic [AW-1:0]      desc_src,
    input  logic [AW-1:0]      desc_dst,
    input  logic [LW-1:0]      desc_len,
    input  logic [AW-1:0]      desc_db_addr,
    input  logic [7:0]         desc_db_attr,
    input  logic [31:0]        desc_db_data,
    input  logic [NSEM*32-1:0] desc_sem,
    output logic               sem_valid,
    input  logic               sem_ready,
    output logic [31:0]        sem_word,
    output logic               dma_valid,
    input  logic               dma_ready,
    output logic [1:0]         dma_dir,
    output logic               dma_bulk,
    output logic [AW-1:0]      dma_src,
    output logic [AW-1:0]      dma_dst,
    output logic [LW-1:0]      dma_len,
    input  logic               dma_done,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [AW-1:0]      wr_addr,
    output logic [31:0]        wr_data,
    output logic [1:0]         wr_size,
    output logic               cpl_valid,
    input  logic               cpl_ready,
    output logic [15:0]        cpl_req_id,
    output logic [15:0]        cpl_status,
    output logic               cpl_irq
);
    import dsq_pkg::*;

    dsq_state_e          state;
    logic [15:0]         r_id;
    logic [7:0]          r_cmd;
    logic [AW-1:0]       r_src;
    logic [AW-1:0]       r_dst;
    logic [LW-1:0]       r_len;
    logic [AW-1:0]       r_dba;
    logic [7:0]          r_attr;
    logic [31:0]         r_data;
    logic [NSEM*32-1:0]  r_sem;
    logic [NSEM-1:0]     post_done;

    logic [31:0]         sem_arr [NSEM];
    logic [1:0]          xfer;
    logic                bulk, cpl_en, irq, db_en, pre_found, misaligned;
    logic [1:0]          db_size;
    logic [SIW-1:0]      pre_idx, post_idx;
    logic [NSEM-1:0]     post_mask, post_left;
    logic                post_any;
    logic [15:0]         status;
    logic                err;
    dsq_state_e          fin_state;

    for (genvar g = 0; g < NSEM; g++) begin : g_arr
        assign sem_arr[g] = r_sem[g*32 +: 32];
    end

    dsq_db_shape u_shape (
        .size       (r_attr[1:0]),
        .addr_lo    (r_dba[1:0]),
        .data_in    (r_data),
        .data_out   (wr_data),
        .misaligned (misaligned)
    );

    dsq_decode #(.NSEM(NSEM)) u_dec (
        .cmd           (r_cmd),
        .attr          (r_attr),
        .db_misaligned (misaligned),
        .sem           (r_sem),
        .xfer          (xfer),
        .bulk          (bulk),
        .cpl_en        (cpl_en),
        .irq           (irq),
        .db_en         (db_en),
        .db_size       (db_size),
        .pre_found     (pre_found),
        .pre_idx       (pre_idx),
        .post_mask     (post_mask),
        .status        (status)
    );

    assign post_left = post_mask & ~post_done;

    dsq_lsb_pick #(.N(NSEM)) u_post_pick (
        .mask  (post_left),
        .found (post_any),
        .idx   (post_idx)
    );

    assign err       = (status != ST_OK);
    assign fin_state = cpl_en ? S_CPL : S_IDLE;

    // Capture the descriptor when it is accepted.
    always_ff @(posedge clk) begin
        if (desc_valid && desc_ready) begin
            r_id   <= desc_req_id;
            r_cmd  <= desc_cmd;
            r_src  <= desc_src;
            r_dst  <= desc_dst;
            r_len  <= desc_len;
            r_dba  <= desc_db_addr;
            r_attr <= desc_db_attr;
            r_data <= desc_db_data;
            r_sem  <= desc_sem;
        end
    end

    // Phase sequencer and record of trailing words already issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            post_done <= '0;
        end else begin
            case (state)
                S_IDLE: if (desc_valid) begin
                    state     <= S_PRE;
                    post_done <= '0;
                end
                S_PRE: begin
                    if (err)                         state <= fin_state;
                    else if (!pre_found || sem_ready) state <= S_DMA;
                end
                S_DMA: begin
                    if (xfer == XF_NONE)  state <= S_POST;
                    else if (dma_ready)   state <= S_DMAW;
                end
                S_DMAW: if (dma_done) state <= S_POST;
                S_POST: begin
                    if (!post_any)      state <= S_DB;
                    else if (sem_ready) post_done[post_idx] <= 1'b1;
                end
                S_DB:  if (!db_en || wr_ready) state <= fin_state;
                S_CPL: if (cpl_ready)          state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the handshake outputs from the current phase.
    always_comb begin
        desc_ready = (state == S_IDLE);
        sem_valid  = (state == S_PRE && !err && pre_found) ||
                     (state == S_POST && post_any);
        sem_word   = (state == S_PRE) ? sem_arr[pre_idx] : sem_arr[post_idx];
        dma_valid  = (state == S_DMA) && (xfer != XF_NONE);
        wr_valid   = (state == S_DB) && db_en;
        cpl_valid  = (state == S_CPL);
    end

    assign dma_dir    = xfer;
    assign dma_bulk   = bulk;
    assign dma_src    = r_src;
    assign dma_dst    = r_dst;
    assign dma_len    = r_len;
    assign wr_addr    = r_dba;
    assign wr_size    = db_size;
    assign cpl_req_id = r_id;
    assign cpl_status = status;
    assign cpl_irq    = irq;

    // R1: idle means no downstream request
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !(sem_valid || dma_valid || wr_valid || cpl_valid));

    // R3: phases never overlap
    p_one_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sem_valid, dma_valid, wr_valid, cpl_valid}));

    // R2: a transfer request always carries a legal direction
    p_dma_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid |-> (dma_dir == 2'd1 || dma_dir == 2'd2));

    // R4: a doorbell write never uses the reserved width
    p_wr_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_size != DBW_RSV));

    // R8: only enabled semaphore words leave the block
    p_sem_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sem_valid |-> sem_word[SEM_EN_BIT]);

    // R9: held requests keep their payload
    p_sem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sem_valid && !sem_ready |=> sem_valid && $stable(sem_word));
    p_dma_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid && !dma_ready |=> dma_valid && $stable(dma_dir) && $stable(dma_src));
    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr));
    p_cpl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_status) && $stable(cpl_req_id));

endmodule

// File: tb/dma_desc_seq_test.sv
module dma_desc_seq_test;

    localparam int AW = 64;
    localparam int LW = 32;
    localparam int NSEM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic               desc_valid = 1'b0;
    logic               desc_ready;
    logic [15:0]        desc_req_id = '0;
    logic [7:0]         desc_cmd = '0;
    logic [AW-1:0]      desc_src = '0, desc_dst = '0, desc_db_addr = '0;
    logic [LW-1:0]      desc_len = '0;
    logic [7:0]         desc_db_attr = '0;
    logic [31:0]        desc_db_data = '0;
    logic [NSEM*32-1:0] desc_sem = '0;
    logic               sem_valid, sem_ready = 1'b0;
    logic [31:0]        sem_word;
    logic               dma_valid, dma_ready = 1'b0, dma_done = 1'b0, dma_bulk;
    logic [1:0]         dma_dir;
    logic [AW-1:0]      dma_src, dma_dst, wr_addr;
    logic [LW-1:0]      dma_len;
    logic               wr_valid, wr_ready = 1'b0;
    logic [31:0]        wr_data;
    logic [1:0]         wr_size;
    logic               cpl_valid, cpl_ready = 1'b0, cpl_irq;
    logic [15:0]        cpl_req_id, cpl_status;

    dma_desc_seq #(.AW(AW), .LW(LW), .NSEM(NSEM)) uut (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_req_id(desc_req_id), .desc_cmd(desc_cmd),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_len(desc_len),
        .desc_db_addr(desc_db_addr), .desc_db_attr(desc_db_attr),
        .desc_db_data(desc_db_data), .desc_sem(desc_sem),
        .sem_valid(sem_valid), .sem_ready(sem_ready), .sem_word(sem_word),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_dir(dma_dir),
        .dma_bulk(dma_bulk), .dma_src(dma_src), .dma_dst(dma_dst),
        .dma_len(dma_len), .dma_done(dma_done),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_size(wr_size),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_req_id(cpl_req_id),
        .cpl_status(cpl_status), .cpl_irq(cpl_irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Event log filled by the responders: {kind, value}
    // kind 1 semaphore (value = word[11:0]), 2 DMA (value = dir), 3 doorbell (value = size)
    logic [15:0] ev_log [16];
    int          ev_n = 0;
    int          cpl_n = 0;
    logic [15:0] got_id, got_st;
    logic        got_irq, got_bulk;
    logic [31:0] got_wdata;
    bit          dma_hold = 0, cpl_hold = 0;
    int          dma_cnt = 0;

    task automatic log_ev(input logic [15:0] e);
        if (ev_n < 16) ev_log[ev_n] = e;
        ev_n++;
    endtask

    // Responders act on falling edges; each request is logged when ready is raised.
    always @(negedge clk) begin
        if (sem_ready) sem_ready = 1'b0;
        else if (sem_valid) begin log_ev({4'h1, sem_word[11:0]}); sem_ready = 1'b1; end

        if (dma_done) dma_done = 1'b0;
        if (dma_cnt > 0) begin
            dma_cnt--;
            if (dma_cnt == 0) dma_done = 1'b1;
        end
        if (dma_ready) begin dma_ready = 1'b0; dma_cnt = 3; end
        else if (dma_valid && !dma_hold) begin
            log_ev({4'h2, 10'h0, dma_dir}); got_bulk = dma_bulk; dma_ready = 1'b1;
        end

        if (wr_ready) wr_ready = 1'b0;
        else if (wr_valid) begin
            log_ev({4'h3, 10'h0, wr_size}); got_wdata = wr_data; wr_ready = 1'b1;
        end

        if (cpl_ready) cpl_ready = 1'b0;
        else if (cpl_valid && !cpl_hold) begin
            cpl_n++; got_id = cpl_req_id; got_st = cpl_status; got_irq = cpl_irq;
            cpl_ready = 1'b1;
        end
    end

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  attr;
        logic [1:0]  alo;
        logic [31:0] data;
        logic [31:0] s0, s1, s2, s3;
        logic [15:0] st;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{8'h19, 8'h80, 2'd0, 32'hDEADBEEF, 32'h80400001, 32'h80000002, 32'h00000003, 32'h80000004, 16'd0},
        '{8'h92, 8'h81, 2'd2, 32'h1234ABCD, 32'h0, 32'h0, 32'h0, 32'h0, 16'd0},
        '{8'h10, 8'h82, 2'd3, 32'h11223344, 32'h0, 32'h0, 32'h80400005, 32'h0, 16'd0},
        '{8'h13, 8'h80, 2'd0, 32'h0, 32'h80000006, 32'h0, 32'h0, 32'h0, 16'd1},
        '{8'h11, 8'h83, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 16'd2},
        '{8'h11, 8'h80, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 16'd3},
        '{8'h11, 8'h81, 2'd1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 16'd3},
        '{8'h91, 8'h00, 2'd0, 32'h0, 32'h0, 32'h80400007, 32'h0, 32'h80400008, 16'd4},
        '{8'h01, 8'h00, 2'd0, 32'h0, 32'h80000009, 32'h0, 32'h0, 32'h0, 16'd0},
        '{8'h03, 8'h00, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 16'd1},
        '{8'h10, 8'h03, 2'd1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 16'd0},
        '{8'h1B, 8'h00, 2'd0, 32'h0, 32'h80400001, 32'h80400002, 32'h0, 32'h0, 16'd1},
        '{8'h12, 8'h83, 2'd0, 32'h0, 32'h80400001, 32'h0, 32'h0, 32'h80400002, 16'd4}
    };

    task automatic send(input logic [15:0] id, input vec_t v);
        @(negedge clk);
        desc_valid   = 1'b1;
        desc_req_id  = id;
        desc_cmd     = v.cmd;
        desc_src     = 64'h1000_0000;
        desc_dst     = 64'h2000_0000;
        desc_len     = 32'h40;
        desc_db_addr = 64'hF000_1000 | {62'h0, v.alo};
        desc_db_attr = v.attr;
        desc_db_data = v.data;
        desc_sem     = {v.s3, v.s2, v.s1, v.s0};
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int t;
        t = 0;
        while (!desc_ready && t < 200) begin @(negedge clk); t++; end
        if (t >= 200) begin n_chk++; n_bad++; $display("FAIL %s actual=busy expected=idle", req); end
    endtask

    int wd = 0;
    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<100000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_ev [16];
        int          exp_n;
        logic [31:0] w [4];
        logic [31:0] exp_wd;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset desc_ready", 64'(desc_ready), 64'd1);
        check("R1 reset valids", 64'({sem_valid, dma_valid, wr_valid, cpl_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 64'(desc_ready), 64'd1);

        for (int i = 0; i < NV; i++) begin
            ev_n = 0; cpl_n = 0;
            send(16'hA000 + 16'(i), VT[i]);
            wait_idle("R10 finish");
            repeat (2) @(negedge clk);

            // Expected sequence from the requirements (R2 R3 R4 R8)
            w[0] = VT[i].s0; w[1] = VT[i].s1; w[2] = VT[i].s2; w[3] = VT[i].s3;
            exp_n = 0;
            if (VT[i].st == 16'd0) begin
                for (int k = 0; k < 4; k++)
                    if (w[k][31] && w[k][22]) begin exp_ev[exp_n] = {4'h1, w[k][11:0]}; exp_n++; end
                if (VT[i].cmd[1:0] != 2'd0) begin exp_ev[exp_n] = {4'h2, 10'h0, VT[i].cmd[1:0]}; exp_n++; end
                for (int k = 0; k < 4; k++)
                    if (w[k][31] && !w[k][22]) begin exp_ev[exp_n] = {4'h1, w[k][11:0]}; exp_n++; end
                if (VT[i].attr[7]) begin exp_ev[exp_n] = {4'h3, 10'h0, VT[i].attr[1:0]}; exp_n++; end
            end
            // R6: error requests reach no agent; R3: phase count
            check($sformatf("R3 R6 event count v%0d", i), 64'(ev_n), 64'(exp_n));
            for (int k = 0; k < exp_n && k < ev_n; k++)
                check($sformatf("R3 event order v%0d e%0d", i, k), 64'(ev_log[k]), 64'(exp_ev[k]));
            if (VT[i].st == 16'd0 && VT[i].cmd[1:0] != 2'd0)
                check($sformatf("R2 bulk flag v%0d", i), 64'(got_bulk), 64'(VT[i].cmd[3]));
            if (VT[i].st == 16'd0 && VT[i].attr[7]) begin
                case (VT[i].attr[1:0])
                    2'd1:    exp_wd = {16'h0, VT[i].data[15:0]};
                    2'd2:    exp_wd = {24'h0, VT[i].data[7:0]};
                    default: exp_wd = VT[i].data;
                endcase
                check($sformatf("R4 doorbell data v%0d", i), 64'(got_wdata), 64'(exp_wd));
            end
            // R7: completion presence and content
            check($sformatf("R7 record count v%0d", i), 64'(cpl_n), 64'(VT[i].cmd[4]));
            if (VT[i].cmd[4] && cpl_n == 1) begin
                check($sformatf("R7 req id v%0d", i), 64'(got_id), 64'(16'hA000 + 16'(i)));
                check($sformatf("R5 R6 status v%0d", i), 64'(got_st), 64'(VT[i].st));
                check($sformatf("R7 irq flag v%0d", i), 64'(got_irq), 64'(VT[i].cmd[7]));
            end
        end

        // R9: completion held under back-pressure keeps its content
        cpl_hold = 1; ev_n = 0; cpl_n = 0;
        send(16'hBEEF, '{8'h93, 8'h00, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 16'd1});
        repeat (5) @(negedge clk);
        check("R9 cpl held valid", 64'(cpl_valid), 64'd1);
        check("R9 cpl held status", 64'(cpl_status), 64'd1);
        check("R9 cpl held id", 64'(cpl_req_id), 64'hBEEF);
        cpl_hold = 0;
        wait_idle("R9 release");
        check("R9 one record", 64'(cpl_n), 64'd1);

        // R10: reset while the transfer request is stalled
        dma_hold = 1; ev_n = 0;
        send(16'h0042, '{8'h12, 8'h80, 2'd0, 32'h5, 32'h0, 32'h0, 32'h0, 32'h0, 16'd0});
        repeat (4) @(negedge clk);
        check("R2 stalled dma dir", 64'({dma_valid, dma_dir}), 64'h6);
        check("R9 dma still valid", 64'(dma_valid), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        dma_hold = 0;
        check("R10 idle after reset", 64'(desc_ready), 64'd1);
        check("R10 nothing pending", 64'({sem_valid, dma_valid, wr_valid, cpl_valid}), 64'd0);
        repeat (6) @(negedge clk);
        check("R10 no further events", 64'(ev_n), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule